// File: doc/BRIEF.md
# Emergency Output-Disable Input Detector

This block watches one active-low emergency input and latches a fault flag when it sees a valid request on it. While the flag is set, the block can force a group of outputs to high impedance through an output-enable-kill signal, and it can raise an interrupt request. Each of these is switched on by its own enable bit. The block does not drive the pins itself.

A two-bit mode field selects how a request is accepted. The first mode accepts a falling edge. The other three accept a run of sixteen consecutive low samples, taken at the clock divided by 8, 16 or 128. Software uses a small synchronous register port to set the mode and the enables and to observe and clear the flag.

The flag is held in a three-state machine:
- `FL_CLEAR`: no fault is latched.
- `FL_RAISED`: a fault is latched but has not yet been read.
- `FL_SEEN`: the flag has been read as 1, so a clearing write is now allowed.

The transitions are:
- CLEAR→RAISED on a detection.
- RAISED→SEEN on a read.
- SEEN→CLEAR on a write of 0 to the flag when no detection occurs in that cycle.
- SEEN→RAISED on a clearing write that meets a detection.

Top module: `poe_detect`

## Requirements
- R1: After reset, every control bit and the flag are 0, so `rdata` reads 0, and `oe_kill` and `irq_req` are low.
- R2: In mode 00 (`rdata[1:0]`), a falling edge on `pin_n` sets the flag (`rdata[12]`), even if the low pulse lasts only a few cycles. The flag becomes visible on the third rising clock edge after the pin falls.
- R3: In modes 01, 10 and 11, the flag sets only after 16 consecutive low samples of the synchronized input, taken every 8, 16 and 128 clocks respectively. A single high sample restarts the run, so a shorter low period does not set the flag.
- R4: Once set, the flag stays set after `pin_n` returns high.
- R5: A write of 1 to bit 12 leaves the flag unchanged. A write of 0 to bit 12 is ignored if the flag has not been read as 1 since it was set.
- R6: A read that returns the flag as 1, followed by a write with bit 12 at 0, clears the flag.
- R7: If a clearing write meets a new detection in the same cycle, the flag stays set.
- R8: The mode field (bits 1:0) and the interrupt enable (bit 8) take the value of the first write after reset only. Later writes to them are ignored.
- R9: The high-impedance enable (bit 9) can be rewritten at any time. `oe_kill` is high exactly while the flag and this bit are both 1.
- R10: `irq_req` is high exactly while the flag and the interrupt enable are both 1.
- R11: Bits 15:13, 11:10 and 7:2 of `rdata` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| pin_n | input | 1 | Asynchronous active-low emergency input |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data |
| oe_kill | output | 1 | Force controlled outputs to high impedance |
| irq_req | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a clearing write of 0 and a fresh detection. The bench first sets the flag and reads it as 1. It then releases the pin and pulls it low again. The write strobe is timed so that it lands in the cycle in which the new falling edge has just reached the synchronizer output. The flag must still be set afterwards. The same write without a detection must clear the flag, which shows that the write alone is effective.

// File: rtl/poe_pkg.sv
package poe_pkg;
    typedef enum logic [1:0] {
        MODE_EDGE  = 2'b00,
        MODE_DIV_A = 2'b01,
        MODE_DIV_B = 2'b10,
        MODE_DIV_C = 2'b11
    } accept_mode_e;

    typedef enum logic [1:0] {
        FL_CLEAR  = 2'b00,
        FL_RAISED = 2'b01,
        FL_SEEN   = 2'b10
    } flag_state_e;

    localparam int REG_W      = 16;
    localparam int BIT_IE     = 8;
    localparam int BIT_HIZ    = 9;
    localparam int BIT_FLAG   = 12;
    localparam int NUM_RATES  = 3;
endpackage

// File: rtl/poe_sync.sv
module poe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/poe_prescale.sv
module poe_prescale #(
    parameter int DIV_A = 8,
    parameter int DIV_B = 16,
    parameter int DIV_C = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic [poe_pkg::NUM_RATES-1:0] ticks
);
    localparam int CNT_W = $clog2(DIV_C);
    localparam int DIVS [poe_pkg::NUM_RATES] = '{DIV_A, DIV_B, DIV_C};

    logic [CNT_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    for (genvar i = 0; i < poe_pkg::NUM_RATES; i++) begin : g_tick
        localparam int LW = $clog2(DIVS[i]);
        assign ticks[i] = &div_q[LW-1:0];
    end
endmodule

// File: rtl/poe_accept.sv
module poe_accept
    import poe_pkg::*;
#(
    parameter int RUN_LEN = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pin_s,
    input  accept_mode_e          mode,
    input  logic [NUM_RATES-1:0]  ticks,
    output logic                  detect
);
    localparam int RUN_W = $clog2(RUN_LEN);

    logic             prev_q;
    logic [RUN_W-1:0] run_q;
    logic             tick_sel;
    logic             edge_hit;
    logic             run_hit;

    always_comb begin
        unique case (mode)
            MODE_DIV_A: tick_sel = ticks[0];
            MODE_DIV_B: tick_sel = ticks[1];
            MODE_DIV_C: tick_sel = ticks[2];
            default:    tick_sel = 1'b0;
        endcase
    end

    assign edge_hit = (mode == MODE_EDGE) && prev_q && !pin_s;
    assign run_hit  = tick_sel && !pin_s && (run_q == RUN_W'(RUN_LEN - 1));
    assign detect   = edge_hit || run_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            run_q  <= '0;
        end else begin
            prev_q <= pin_s;
            if (tick_sel) begin
                if (pin_s || run_hit) run_q <= '0;
                else                  run_q <= run_q + 1'b1;
            end
        end
    end

    // R3
    high_sample_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_sel && pin_s) |=> (run_q == '0));
endmodule

// File: rtl/poe_detect.sv
module poe_detect
    import poe_pkg::*;
#(
    parameter int DIV_A   = 8,
    parameter int DIV_B   = 16,
    parameter int DIV_C   = 128,
    parameter int RUN_LEN = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        oe_kill,
    output logic        irq_req
);
    logic                 pin_s;
    logic [NUM_RATES-1:0] ticks;
    logic                 detect;
    accept_mode_e         mode_q;
    logic                 ie_q;
    logic                 hiz_q;
    logic                 locked_q;
    flag_state_e          fl_q, fl_d;
    logic                 flag;
    logic                 clear_wr;

    poe_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_n), .sync_out(pin_s)
    );

    poe_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
        .clk(clk), .rst_n(rst_n), .ticks(ticks)
    );

    poe_accept #(.RUN_LEN(RUN_LEN)) u_acc (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .mode(mode_q),
        .ticks(ticks), .detect(detect)
    );

    // Control register: mode and interrupt enable lock after first write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_EDGE;
            ie_q     <= 1'b0;
            hiz_q    <= 1'b0;
            locked_q <= 1'b0;
        end else if (wr_en) begin
            hiz_q <= wdata[BIT_HIZ];
            if (!locked_q) begin
                mode_q   <= accept_mode_e'(wdata[1:0]);
                ie_q     <= wdata[BIT_IE];
                locked_q <= 1'b1;
            end
        end
    end

    assign clear_wr = wr_en && !wdata[BIT_FLAG];

    // Flag state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= FL_CLEAR;
        else        fl_q <= fl_d;
    end

    // Flag next-state logic
    always_comb begin
        fl_d = fl_q;
        unique case (fl_q)
            FL_CLEAR:  if (detect) fl_d = FL_RAISED;
            FL_RAISED: if (rd_en)  fl_d = FL_SEEN;
            FL_SEEN: begin
                if (clear_wr && detect) fl_d = FL_RAISED;
                else if (clear_wr)      fl_d = FL_CLEAR;
            end
            default:                    fl_d = FL_CLEAR;
        endcase
    end

    // Outputs
    always_comb begin
        flag                = (fl_q != FL_CLEAR);
        oe_kill             = flag && hiz_q;
        irq_req             = flag && ie_q;
        rdata               = '0;
        rdata[1:0]          = mode_q;
        rdata[BIT_IE]       = ie_q;
        rdata[BIT_HIZ]      = hiz_q;
        rdata[BIT_FLAG]     = flag;
    end

    // R8
    locked_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && wr_en) |=> ($stable(mode_q) && $stable(ie_q)));

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_en) |=> flag);

    // R7
    detect_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && detect) |=> flag);

    // R6
    clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clear_wr));

    // R2
    detect_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        detect |=> flag);
endmodule

// File: tb/poe_detect_test.sv
module poe_detect_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_n = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        oe_kill;
    logic        irq_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    poe_detect uut (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .oe_kill(oe_kill), .irq_req(irq_req)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] low_len;
        logic        expect_flag;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 16'd3,    1'b1},
        '{2'b01, 16'd40,   1'b0},
        '{2'b01, 16'd200,  1'b1},
        '{2'b10, 16'd100,  1'b0},
        '{2'b10, 16'd300,  1'b1},
        '{2'b11, 16'd1000, 1'b0},
        '{2'b11, 16'd2300, 1'b1}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; pin_n = 1'b1; wdata = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] w);
        @(negedge clk);
        wr_en = 1'b1; wdata = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(output logic [15:0] r);
        @(negedge clk);
        rd_en = 1'b1;
        #1 r = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] r;
        // R1 and R11 reset state
        do_reset();
        rd(r);
        check("R1 reset rdata", r, 16'h0000);
        check("R1 reset outputs", {14'd0, oe_kill, irq_req}, 16'h0000);

        // Table-driven acceptance (R2, R3, R4, R9, R10)
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr({3'b000, 1'b0, 2'b00, 1'b1, 1'b1, 6'd0, VECS[i].mode});
            @(negedge clk);
            pin_n = 1'b0;
            repeat (int'(VECS[i].low_len)) @(negedge clk);
            pin_n = 1'b1;
            repeat (4) @(negedge clk);
            rd(r);
            check($sformatf("R3/R2 vec%0d flag", i), {15'd0, r[12]}, {15'd0, VECS[i].expect_flag});
            check($sformatf("R9/R10 vec%0d outputs", i), {14'd0, oe_kill, irq_req},
                  {14'd0, VECS[i].expect_flag, VECS[i].expect_flag});
            check($sformatf("R11 vec%0d reserved", i), r & 16'hECFC, 16'h0000);
        end

        // R2 exact latency: flag after third rising edge
        do_reset();
        wr(16'h0000);
        @(negedge clk);
        pin_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 not yet after two edges", {15'd0, rdata[12]}, 16'h0000);
        @(negedge clk);
        check("R2 set after third edge", {15'd0, rdata[12]}, 16'h0001);
        pin_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R4 flag sticky", {15'd0, rdata[12]}, 16'h0001);

        // R5 write 0 without read, write 1 after read
        wr(16'h0000);
        check("R5 clear without read ignored", {15'd0, rdata[12]}, 16'h0001);
        rd(r);
        wr(16'h1000);
        check("R5 write 1 no effect", {15'd0, rdata[12]}, 16'h0001);
        // R6 clear after read
        wr(16'h0000);
        check("R6 clear after read", {15'd0, rdata[12]}, 16'h0000);

        // R7 collision: clearing write in the detection cycle
        @(negedge clk);
        pin_n = 1'b0;
        repeat (3) @(negedge clk);
        rd(r);
        check("R7 setup flag", {15'd0, r[12]}, 16'h0001);
        pin_n = 1'b1;
        repeat (4) @(negedge clk);
        pin_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wdata = 16'h0000;
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 detection beats clear", {15'd0, rdata[12]}, 16'h0001);
        pin_n = 1'b1;

        // R8 write-once and R9 hiz rewritable
        do_reset();
        wr(16'h0101);
        wr(16'h0002);
        rd(r);
        check("R8 mode/ie locked", r, 16'h0101);
        wr(16'h0201);
        rd(r);
        check("R9 hiz writable", r, 16'h0301);
        @(negedge clk);
        pin_n = 1'b0;
        repeat (200) @(negedge clk);
        pin_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 oe_kill on", {15'd0, oe_kill}, 16'h0001);
        wr(16'h1001);
        check("R9 oe_kill off with hiz 0", {15'd0, oe_kill}, 16'h0000);
        check("R10 irq with ie", {15'd0, irq_req}, 16'h0001);

        // R10 ie clear keeps irq low
        do_reset();
        wr(16'h0200);
        @(negedge clk);
        pin_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 no irq when ie 0", {14'd0, oe_kill, irq_req}, 16'h0002);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule